// File: doc/BRIEF.md
# Square-and-Multiply Modular Exponentiator

This block raises a base to a power modulo a modulus using the left-to-right binary method. After a start request it captures the base, the modulus and the exponent. It sets its accumulator to one, then visits every exponent bit from the most significant bit to bit 0. On each bit it squares the accumulator modulo the modulus. When the bit is 1 it also multiplies the accumulator by the base, right after that squaring. All arithmetic runs on one shared bit-serial modular multiplier. The multiplier interleaves a doubling step and a conditional add, and reduces by one conditional subtraction after each of the two.

A two-bit trace output names the operation that the multiplier is running in every cycle. It reads idle, square or multiply. Because the multiply slots appear only for 1 bits, the trace shows the exponent bit by bit. The block is meant as a teaching and test vehicle for leakage through the operation sequence. When the result is ready it is held on the result port, and a one-cycle done pulse marks it.

Top module: `modexp_sqmul`

## Requirements
- R1: After reset, trace reads idle (2'b00), done is low and result is 0.
- R2: The accumulator starts at 1 reduced modulo N. An exponent of 0 therefore gives result 1, and a modulus of 1 gives result 0.
- R3: Exponent bits are visited from bit KW-1 down to bit 0, all KW of them. Each visited bit starts with one squaring.
- R4: A multiplication by X happens for a bit only when that bit is 1, and it follows that bit's squaring directly.
- R5: The trace code is 2'b01 while squaring and 2'b10 while multiplying, and it never reads 2'b11. Each operation holds its code for exactly W+2 cycles, starting in the cycle after start is sampled.
- R6: For 1 <= N and X < N, result equals X^K mod N. It is written in the cycle after the last operation ends. done is high for that one cycle only and trace returns to idle at the same time. result then holds until the next run finishes.
- R7: A start asserted while an exponentiation is running is ignored. The trace sequence and the result of the running operation are unchanged.
- R8: An exponent whose leading bits are 1,0,1,0,0,0 yields the operation order square, multiply, square, square, multiply, square, square, square.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an exponentiation when idle |
| x_in | input | W | Base, must be below the modulus |
| n_in | input | W | Modulus, at least 1 |
| k_in | input | KW | Exponent |
| result | output | W | Registered X^K mod N |
| done | output | 1 | One-cycle pulse when result is new |
| trace | output | 2 | 00 idle, 01 square, 10 multiply |

## Verification
The assertions take for granted that each start presents a modulus of at least 1 and a base strictly below it. The reduced-accumulator and result-range properties rely on those bounds. The stimulus picks every base as a value already reduced by the chosen modulus, and never drives a zero modulus. Start pulses that arrive during a run carry operands that may break these bounds. This is allowed because the design must drop them.

// File: rtl/modexp_pkg.sv
package modexp_pkg;
  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_SQR  = 2'b01,
    TR_MUL  = 2'b10
  } trace_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_SQR  = 2'b01,
    ST_MUL  = 2'b10
  } state_t;
endpackage

// File: rtl/modexp_mulmod.sv
module modexp_mulmod #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] n,
  output logic [W-1:0] prod,
  output logic         fin,
  output logic         busy
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  acc, a_r, b_sh, n_r;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    dbl, red1, sum, red2;

  // one interleaved step: double, reduce, conditionally add, reduce
  always_comb begin
    dbl  = {acc, 1'b0};
    red1 = (dbl >= {1'b0, n_r}) ? dbl - {1'b0, n_r} : dbl;
    sum  = b_sh[W-1] ? red1 + {1'b0, a_r} : red1;
    red2 = (sum >= {1'b0, n_r}) ? sum - {1'b0, n_r} : sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      a_r  <= '0;
      b_sh <= '0;
      n_r  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        acc  <= '0;
        a_r  <= a;
        b_sh <= b;
        n_r  <= n;
        cnt  <= CW'(W);
        run  <= 1'b1;
      end else if (run) begin
        acc  <= red2[W-1:0];
        b_sh <= {b_sh[W-2:0], 1'b0};
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assign prod = acc;
  assign busy = run;

  // accumulator stays reduced while the step loop runs (R6)
  assert_acc_reduced_R6: assert property (@(posedge clk) disable iff (rst)
    (run && n_r != '0) |-> (acc < n_r));

  // finish is a single-cycle pulse (R5)
  assert_fin_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);
endmodule

// File: rtl/modexp_keyscan.sv
module modexp_keyscan #(
  parameter int KW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic [KW-1:0] k,
  output logic          cur_bit,
  output logic          last
);
  localparam int CW = (KW > 1) ? $clog2(KW) : 1;

  logic [KW-1:0] ksh;
  logic [CW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      ksh <= '0;
      pos <= '0;
    end else if (load) begin
      ksh <= k;
      pos <= '0;
    end else if (adv) begin
      ksh <= ksh << 1;
      pos <= pos + 1'b1;
    end
  end

  assign cur_bit = ksh[KW-1];
  assign last    = (pos == CW'(KW - 1));

  // never advance beyond the final exponent bit (R3)
  assert_no_overrun_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && !load) |-> !last);
endmodule

// File: rtl/modexp_sqmul.sv
module modexp_sqmul
  import modexp_pkg::*;
#(
  parameter int W  = 16,
  parameter int KW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  x_in,
  input  logic [W-1:0]  n_in,
  input  logic [KW-1:0] k_in,
  output logic [W-1:0]  result,
  output logic          done,
  output logic [1:0]    trace
);
  state_t        state;
  trace_t        trace_q;
  logic [W-1:0]  z, x_r, n_r, prod, op_a;
  logic          go, mfin, mbusy, cur_bit, last, load, adv;

  assign load = (state == ST_IDLE) && start;
  assign adv  = mfin && !last &&
                ((state == ST_MUL) || (state == ST_SQR && !cur_bit));
  assign op_a = (state == ST_MUL) ? x_r : z;

  modexp_keyscan #(.KW(KW)) u_keys (
    .clk(clk), .rst(rst), .load(load), .adv(adv), .k(k_in),
    .cur_bit(cur_bit), .last(last)
  );

  modexp_mulmod #(.W(W)) u_mul (
    .clk(clk), .rst(rst), .go(go), .a(op_a), .b(z), .n(n_r),
    .prod(prod), .fin(mfin), .busy(mbusy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      trace_q <= TR_IDLE;
      z       <= '0;
      x_r     <= '0;
      n_r     <= '0;
      go      <= 1'b0;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          x_r     <= x_in;
          n_r     <= n_in;
          z       <= (n_in == W'(1)) ? '0 : W'(1);
          state   <= ST_SQR;
          trace_q <= TR_SQR;
          go      <= 1'b1;
        end
        ST_SQR: if (mfin) begin
          z <= prod;
          if (cur_bit) begin
            state   <= ST_MUL;
            trace_q <= TR_MUL;
            go      <= 1'b1;
          end else if (last) begin
            result  <= prod;
            done    <= 1'b1;
            state   <= ST_IDLE;
            trace_q <= TR_IDLE;
          end else begin
            go <= 1'b1;
          end
        end
        ST_MUL: if (mfin) begin
          z <= prod;
          if (last) begin
            result  <= prod;
            done    <= 1'b1;
            state   <= ST_IDLE;
            trace_q <= TR_IDLE;
          end else begin
            state   <= ST_SQR;
            trace_q <= TR_SQR;
            go      <= 1'b1;
          end
        end
        default: begin
          state   <= ST_IDLE;
          trace_q <= TR_IDLE;
        end
      endcase
    end
  end

  assign trace = trace_q;

  // trace code is one of the three legal values (R5)
  assert_trace_legal_R5: assert property (@(posedge clk) disable iff (rst)
    trace != 2'b11);

  // a multiply is entered only straight from a squaring (R4)
  assert_mul_after_sqr_R4: assert property (@(posedge clk) disable iff (rst)
    (trace == TR_MUL && $past(trace) != TR_MUL) |-> $past(trace) == TR_SQR);

  // every run opens with a squaring (R3)
  assert_first_op_sqr_R3: assert property (@(posedge clk) disable iff (rst)
    (trace != TR_IDLE && $past(trace) == TR_IDLE) |-> trace == TR_SQR);

  // trace holds while the multiplier is stepping (R5)
  assert_trace_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (mbusy && $past(mbusy)) |-> $stable(trace));

  // done lasts one cycle and leaves a reduced result (R6)
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_result_reduced_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (result < n_r));

  // start while running leaves the captured modulus alone (R7)
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> (state == ST_IDLE || $stable(n_r)));
endmodule

// File: tb/tb_modexp_sqmul.sv
module tb_modexp_sqmul;
  localparam int W  = 16;
  localparam int KW = 16;
  localparam int OPLEN = W + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  x_in = '0, n_in = '0;
  logic [KW-1:0] k_in = '0;
  logic [W-1:0]  result;
  logic          done;
  logic [1:0]    trace;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  modexp_sqmul #(.W(W), .KW(KW)) dut (
    .clk(clk), .rst(rst), .start(start), .x_in(x_in), .n_in(n_in),
    .k_in(k_in), .result(result), .done(done), .trace(trace)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint ref_pow(longint x, longint k, longint n);
    longint z = 1 % n;
    for (int i = KW - 1; i >= 0; i--) begin
      z = (z * z) % n;
      if ((k >> i) & 1) z = (z * x) % n;
    end
    return z;
  endfunction

  // run one exponentiation, comparing trace and done on every cycle
  task automatic run(input string req, input logic [W-1:0] x,
                     input logic [W-1:0] n, input logic [KW-1:0] k,
                     input bit poke);
    logic [1:0] q[$];
    longint exp_res;
    int idx;
    q.delete();
    for (int i = KW - 1; i >= 0; i--) begin
      for (int c = 0; c < OPLEN; c++) q.push_back(2'b01);
      if (k[i]) for (int c = 0; c < OPLEN; c++) q.push_back(2'b10);
    end
    exp_res = ref_pow(longint'(x), longint'(k), longint'(n));
    @(negedge clk);
    x_in = x; n_in = n; k_in = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 0;
    while (q.size() > 0) begin
      chk({req, " trace R5"}, longint'(trace), longint'(q.pop_front()));
      chk({req, " no early done R6"}, longint'(done), 0);
      if (poke && idx == 7) begin
        // R7: new operands with start during the run
        x_in = ~x; n_in = 16'd3; k_in = ~k; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      idx++;
      @(negedge clk);
    end
    chk({req, " done R6"}, longint'(done), 1);
    chk({req, " result R6"}, longint'(result), exp_res);
    chk({req, " trace idle R6"}, longint'(trace), 0);
    @(negedge clk);
    chk({req, " done single R6"}, longint'(done), 0);
    chk({req, " result held R6"}, longint'(result), exp_res);
    chk({req, " stays idle R7"}, longint'(trace), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 trace", longint'(trace), 0);
    chk("R1 done", longint'(done), 0);
    chk("R1 result", longint'(result), 0);

    // R8 leading bits 1,0,1,0,0,0 ; R3 R4 ordering via trace queue
    run("R8", 16'd5, 16'd23, 16'hA000, 1'b0);
    run("R3", 16'd7, 16'd1000, 16'h8001, 1'b0);
    run("R4", 16'd12345, 16'd65521, 16'hFFFF, 1'b0);
    // R2 zero exponent and unit modulus
    run("R2 k0", 16'd9, 16'd97, 16'h0000, 1'b0);
    run("R2 n1", 16'd0, 16'd1, 16'hBEEF, 1'b0);
    run("R6 x0", 16'd0, 16'd101, 16'h0013, 1'b0);
    run("R6 big", 16'd65520, 16'd65521, 16'h5A5A, 1'b0);
    run("R6 mixed", 16'd321, 16'd40000, 16'h1234, 1'b0);
    // R7 start pulse while busy
    run("R7", 16'd11, 16'd257, 16'hC3A5, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule